// File: doc/BRIEF.md
# Receive Byte Buffer with Hysteresis Flow Pacing

This block sits behind a serial deserializer. It stores the received bytes in a 64-entry first-in first-out buffer until the host takes them. A write strobe with a byte arrives from the deserializer. A pop strobe from the host removes the oldest byte, and that byte is always visible on the read data output. The block reports the fill level, an empty flag and a sticky overrun flag. A status-read strobe clears the overrun flag.

The block drives an active-low request-to-send line that paces the remote sender. One 8-bit control byte packs two 4-bit fields: a halt level and a resume level, each counted in units of four bytes. The line is released (high) when the fill level reaches the halt level. It is asserted (low) again only when the level has drained to the resume level, so the line switches with hysteresis. Bytes that arrive after the line is released are still stored. When automatic pacing is disabled, a software bit drives the line.

The pacing controller is a three-state machine:
- `RTS_OPEN`: sending is allowed and the line is low.
- `RTS_HALTED`: the buffer is at or above the halt level and the line is high.
- `RTS_MANUAL`: automatic pacing is off and the line follows the software bit.

Its transitions are:
- OPEN to HALTED when the updated level reaches the halt level.
- HALTED to OPEN when the updated level reaches the resume condition.
- Any state to MANUAL when the enable input is low.
- MANUAL to OPEN or HALTED when the enable returns, chosen by comparing the updated level with the halt level.

Top module: `rx_pacing_fifo`

## Requirements
- R1: The buffer holds up to 64 bytes and returns them in arrival order. While the buffer is not empty, `rd_data` shows the oldest byte, and a `rd_pop` removes that byte at the clock edge.
- R2: `level` gives the number of stored bytes and `empty` is 1 exactly when `level` is 0. Both update at the edge that accepts a push or pop. A `rd_pop` while the buffer is empty has no effect.
- R3: A write strobe while `level` is 64 is dropped and sets `overrun` at that edge. `overrun` stays set until a cycle with `stat_rd` high clears it. If a drop and `stat_rd` occur in the same cycle, the set wins.
- R4: In automatic mode the halt level is `thresh_ctl[3:0]`×4. `rts_n` goes high at the same edge where the updated level becomes greater than or equal to the halt level.
- R5: In automatic mode the resume level is `thresh_ctl[7:4]`×4. When the resume level is below the halt level, `rts_n` stays high while the level is above the resume level. It goes low at the edge where the updated level becomes less than or equal to the resume level.
- R6: When the resume level is greater than or equal to the halt level, a high `rts_n` goes low at the edge where the updated level falls below the halt level.
- R7: Bytes written after `rts_n` has gone high are still stored, as long as the buffer is not full.
- R8: A push and a pop in the same cycle leave `level` unchanged and move one byte through the buffer. At a level of 64, the push in such a cycle is dropped, so the level becomes 63. Every threshold comparison uses the level after the update.
- R9: With `auto_en` low, `rts_n` equals the inverse of `sw_rts`, registered one clock after it is sampled.
- R10: During reset `level` is 0, `empty` is 1, `overrun` is 0 and `rts_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Byte strobe from deserializer |
| wr_data | input | 8 | Received byte |
| rd_pop | input | 1 | Host pop strobe |
| rd_data | output | 8 | Oldest stored byte |
| thresh_ctl | input | 8 | [3:0] halt level /4, [7:4] resume level /4 |
| auto_en | input | 1 | 1 = automatic pacing, 0 = software bit |
| sw_rts | input | 1 | Software request, 1 = assert line (low) |
| stat_rd | input | 1 | Status read, clears overrun |
| level | output | 7 | Stored byte count 0..64 |
| empty | output | 1 | Buffer empty |
| overrun | output | 1 | Sticky dropped-write flag |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
A pointer that drifts by one shows up at the next pop as a wrong byte on `rd_data`. A level counter that is off by one shows up at once on `level` and `empty`. It also moves the `rts_n` switching point by one cycle within the next fill or drain. A pacing state machine stuck in the wrong state shows up as `rts_n` taking the wrong value at the first edge where the level crosses a threshold. The checker flags this within one cycle. The scoreboard flags it within the same step.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [1:0] {
        RTS_OPEN    = 2'd0,
        RTS_HALTED  = 2'd1,
        RTS_MANUAL  = 2'd2
    } rts_state_e;

endpackage

// File: rtl/rxp_store.sv
module rxp_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt,
    output logic          empty,
    output logic          wr_drop
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    assign push_ok = wr_valid && (level != FULL_LVL);
    assign pop_ok  = rd_pop && (level != '0);
    assign wr_drop = wr_valid && (level == FULL_LVL);
    assign rd_data = mem[rd_ptr];

    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   level_nxt = level + LW'(1);
            2'b01:   level_nxt = level - LW'(1);
            default: level_nxt = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            empty  <= 1'b1;
        end else begin
            if (push_ok) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            level <= level_nxt;
            empty <= (level_nxt == '0);
        end
    end

endmodule

// File: rtl/rxp_ovr_flag.sv
module rxp_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/rxp_rts_ctl.sv
module rxp_rts_ctl
    import rxp_pkg::*;
#(
    parameter int LW       = 7,
    parameter int FIELD_W  = 4,
    parameter int TH_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 auto_en,
    input  logic                 sw_rts,
    input  logic [2*FIELD_W-1:0] thresh_ctl,
    input  logic [LW-1:0]        level_nxt,
    output logic                 rts_n
);

    logic [LW-1:0] halt_lvl;
    logic [LW-1:0] resume_lvl;
    logic          at_halt;
    logic          may_resume;
    rts_state_e    state_q;
    rts_state_e    state_d;

    assign halt_lvl   = LW'(thresh_ctl[FIELD_W-1:0]) << TH_SHIFT;
    assign resume_lvl = LW'(thresh_ctl[2*FIELD_W-1:FIELD_W]) << TH_SHIFT;
    assign at_halt    = (level_nxt >= halt_lvl);
    assign may_resume = (resume_lvl >= halt_lvl) ? !at_halt
                                                 : (level_nxt <= resume_lvl);

    always_comb begin
        state_d = state_q;
        if (!auto_en) begin
            state_d = RTS_MANUAL;
        end else begin
            unique case (state_q)
                RTS_OPEN:   state_d = at_halt ? RTS_HALTED : RTS_OPEN;
                RTS_HALTED: state_d = may_resume ? RTS_OPEN : RTS_HALTED;
                RTS_MANUAL: state_d = at_halt ? RTS_HALTED : RTS_OPEN;
                default:    state_d = RTS_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RTS_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_n <= 1'b0;
        end else begin
            unique case (state_d)
                RTS_OPEN:   rts_n <= 1'b0;
                RTS_HALTED: rts_n <= 1'b1;
                RTS_MANUAL: rts_n <= !sw_rts;
                default:    rts_n <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rx_pacing_fifo.sv
module rx_pacing_fifo #(
    parameter int DEPTH    = 64,
    parameter int DW       = 8,
    parameter int FIELD_W  = 4,
    parameter int TH_SHIFT = 2,
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    input  logic [DW-1:0]        wr_data,
    input  logic                 rd_pop,
    output logic [DW-1:0]        rd_data,
    input  logic [2*FIELD_W-1:0] thresh_ctl,
    input  logic                 auto_en,
    input  logic                 sw_rts,
    input  logic                 stat_rd,
    output logic [LW-1:0]        level,
    output logic                 empty,
    output logic                 overrun,
    output logic                 rts_n
);

    logic [LW-1:0] level_nxt;
    logic          wr_drop;

    rxp_store #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .LW    (LW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .rd_pop    (rd_pop),
        .rd_data   (rd_data),
        .level     (level),
        .level_nxt (level_nxt),
        .empty     (empty),
        .wr_drop   (wr_drop)
    );

    rxp_ovr_flag u_ovr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wr_drop),
        .clr_i  (stat_rd),
        .flag_o (overrun)
    );

    rxp_rts_ctl #(
        .LW       (LW),
        .FIELD_W  (FIELD_W),
        .TH_SHIFT (TH_SHIFT)
    ) u_rts (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_en    (auto_en),
        .sw_rts     (sw_rts),
        .thresh_ctl (thresh_ctl),
        .level_nxt  (level_nxt),
        .rts_n      (rts_n)
    );

endmodule

// File: rtl/rxp_checker.sv
module rxp_checker #(
    parameter int DEPTH    = 64,
    parameter int FIELD_W  = 4,
    parameter int TH_SHIFT = 2,
    parameter int LW       = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid,
    input logic                 rd_pop,
    input logic [2*FIELD_W-1:0] thresh_ctl,
    input logic                 auto_en,
    input logic                 sw_rts,
    input logic                 stat_rd,
    input logic [LW-1:0]        level,
    input logic                 empty,
    input logic                 overrun,
    input logic                 rts_n
);

    logic          armed;
    logic [LW-1:0] halt_c;
    logic [LW-1:0] resume_c;

    assign halt_c   = LW'(thresh_ctl[FIELD_W-1:0]) << TH_SHIFT;
    assign resume_c = LW'(thresh_ctl[2*FIELD_W-1:FIELD_W]) << TH_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R1

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0)); // R2

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(level) == '0 && $past(rd_pop) && !$past(wr_valid)) |-> level == '0); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(level) == LW'(DEPTH) && $past(wr_valid) && !$past(rd_pop))
        |-> (level == LW'(DEPTH) && overrun)); // R3

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(overrun) && !$past(stat_rd)) |-> overrun); // R3

    AST_HALT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && auto_en && $past(auto_en) && $stable(thresh_ctl) && level >= halt_c) |-> rts_n); // R4

    AST_HOLD_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && auto_en && $past(auto_en) && $stable(thresh_ctl) && $past(rts_n)
         && resume_c < halt_c && level > resume_c) |-> rts_n); // R5

    AST_OPEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && auto_en && $past(auto_en) && $stable(thresh_ctl) && !$past(rts_n)
         && level < halt_c) |-> !rts_n); // R6

    AST_MANUAL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(auto_en)) |-> rts_n == !$past(sw_rts)); // R9

endmodule

bind rx_pacing_fifo rxp_checker #(
    .DEPTH    (DEPTH),
    .FIELD_W  (FIELD_W),
    .TH_SHIFT (TH_SHIFT),
    .LW       (LW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .rd_pop     (rd_pop),
    .thresh_ctl (thresh_ctl),
    .auto_en    (auto_en),
    .sw_rts     (sw_rts),
    .stat_rd    (stat_rd),
    .level      (level),
    .empty      (empty),
    .overrun    (overrun),
    .rts_n      (rts_n)
);

// File: tb/rx_pacing_fifo_test.sv
module rx_pacing_fifo_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic       rd_pop;
    logic [7:0] rd_data;
    logic [7:0] thresh_ctl;
    logic       auto_en;
    logic       sw_rts;
    logic       stat_rd;
    logic [6:0] level;
    logic       empty;
    logic       overrun;
    logic       rts_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // scoreboard model
    logic [7:0] sb_q[$];
    int  m_lvl    = 0;
    bit  m_halted = 1'b0;
    bit  m_manual = 1'b0;
    bit  m_ovr    = 1'b0;
    bit  m_rts_n  = 1'b0;

    always #4 clk = ~clk;

    rx_pacing_fifo uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .rd_pop     (rd_pop),
        .rd_data    (rd_data),
        .thresh_ctl (thresh_ctl),
        .auto_en    (auto_en),
        .sw_rts     (sw_rts),
        .stat_rd    (stat_rd),
        .level      (level),
        .empty      (empty),
        .overrun    (overrun),
        .rts_n      (rts_n)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare after the edge at the next negedge
    task automatic cycle(input string tag, input bit wv, input logic [7:0] wd,
                         input bit pp, input bit sr);
        int  halt_l;
        int  res_l;
        bit  push_ok;
        bit  pop_ok;
        if (pp && sb_q.size() > 0)
            chk(tag, "rd_data (R1 order)", int'(rd_data), int'(sb_q[0]));
        wr_valid = wv;
        wr_data  = wd;
        rd_pop   = pp;
        stat_rd  = sr;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        rd_pop   = 1'b0;
        stat_rd  = 1'b0;
        push_ok = wv && (m_lvl < 64);
        pop_ok  = pp && (m_lvl > 0);
        if (pop_ok)  void'(sb_q.pop_front());
        if (push_ok) sb_q.push_back(wd);
        m_lvl = m_lvl + int'(push_ok) - int'(pop_ok);
        if (wv && !push_ok) m_ovr = 1'b1;
        else if (sr)        m_ovr = 1'b0;
        halt_l = int'(thresh_ctl[3:0]) * 4;
        res_l  = int'(thresh_ctl[7:4]) * 4;
        if (!auto_en) begin
            m_manual = 1'b1;
            m_rts_n  = !sw_rts;
        end else begin
            if (m_manual)       m_halted = (m_lvl >= halt_l);
            else if (!m_halted) m_halted = (m_lvl >= halt_l);
            else if (res_l >= halt_l) m_halted = !(m_lvl < halt_l);
            else                m_halted = !(m_lvl <= res_l);
            m_manual = 1'b0;
            m_rts_n  = m_halted;
        end
        chk(tag, "level", int'(level), m_lvl);
        chk(tag, "empty", int'(empty), int'(m_lvl == 0));
        chk(tag, "overrun", int'(overrun), int'(m_ovr));
        chk(tag, "rts_n", int'(rts_n), int'(m_rts_n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        wr_valid   = 1'b0;
        wr_data    = 8'h00;
        rd_pop     = 1'b0;
        stat_rd    = 1'b0;
        auto_en    = 1'b1;
        sw_rts     = 1'b0;
        thresh_ctl = 8'h12;           // halt 8, resume 4
        repeat (3) @(negedge clk);
        chk("R10", "level", int'(level), 0);
        chk("R10", "empty", int'(empty), 1);
        chk("R10", "overrun", int'(overrun), 0);
        chk("R10", "rts_n", int'(rts_n), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R7: fill past the halt level
        for (int i = 0; i < 10; i++)
            cycle(i < 8 ? "R4" : "R7", 1'b1, 8'(i * 7 + 3), 1'b0, 1'b0);
        chk("R7", "level after late bytes", int'(level), 10);

        // R5: drain through the band, line low only at 4
        for (int i = 0; i < 6; i++)
            cycle("R5", 1'b0, 8'h00, 1'b1, 1'b0);
        chk("R5", "rts_n at resume", int'(rts_n), 0);

        // R8: push and pop together
        for (int i = 0; i < 3; i++)
            cycle("R8", 1'b1, 8'(8'hA0 + i), 1'b1, 1'b0);

        // R2: drain and pop on empty
        while (m_lvl > 0) cycle("R2", 1'b0, 8'h00, 1'b1, 1'b0);
        cycle("R2", 1'b0, 8'h00, 1'b1, 1'b0);
        cycle("R2", 1'b0, 8'h00, 1'b1, 1'b0);

        // R6: resume at or above halt (12/12)
        thresh_ctl = 8'h33;
        for (int i = 0; i < 13; i++)
            cycle("R6", 1'b1, 8'(i ^ 8'h5C), 1'b0, 1'b0);
        for (int i = 0; i < 3; i++)
            cycle("R6", 1'b0, 8'h00, 1'b1, 1'b0);
        while (m_lvl > 0) cycle("R6", 1'b0, 8'h00, 1'b1, 1'b0);

        // R1 / R3: fill to 64 with halt 60, resume 8
        thresh_ctl = 8'h2F;
        for (int i = 0; i < 64; i++)
            cycle("R1", 1'b1, 8'(i * 13 + 1), 1'b0, 1'b0);
        cycle("R3", 1'b1, 8'hEE, 1'b0, 1'b0);
        chk("R3", "overrun after drop", int'(overrun), 1);
        cycle("R3", 1'b0, 8'h00, 1'b0, 1'b0);
        cycle("R8", 1'b1, 8'hDD, 1'b1, 1'b0);
        cycle("R3", 1'b1, 8'h11, 1'b0, 1'b1);
        cycle("R3", 1'b1, 8'h22, 1'b0, 1'b1);
        cycle("R3", 1'b0, 8'h00, 1'b0, 1'b1);
        chk("R3", "overrun cleared", int'(overrun), 0);
        while (m_lvl > 0) cycle("R1", 1'b0, 8'h00, 1'b1, 1'b0);

        // R9: software-driven line
        auto_en = 1'b0;
        sw_rts  = 1'b1;
        cycle("R9", 1'b0, 8'h00, 1'b0, 1'b0);
        sw_rts  = 1'b0;
        cycle("R9", 1'b0, 8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 62; i++)
            cycle("R9", 1'b1, 8'(i), 1'b0, 1'b0);
        sw_rts  = 1'b1;
        cycle("R9", 1'b0, 8'h00, 1'b0, 1'b0);
        auto_en = 1'b1;
        cycle("R4", 1'b0, 8'h00, 1'b0, 1'b0);
        while (m_lvl > 0) cycle("R5", 1'b0, 8'h00, 1'b1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule